// File: doc/BRIEF.md
# Motor Driver Fault Supervisor

This block supervises protection and power modes for a driver with several H-bridges (two by default). It takes a per-bridge overcurrent-limit flag, an overtemperature flag, an undervoltage flag, an active-low reset pin and an active-low sleep pin. From these it drives a disable line for each bridge, an active-low fault flag, an input-ignore signal, a ready signal, and a supply enable for the charge pump and regulator.

The three protections differ in how they clear. An overcurrent that lasts long enough latches a shutdown of its own bridge. An overtemperature condition shuts down every bridge and clears by itself. An undervoltage condition wipes all internal state. After any blocking condition ends, a wake-up interval counted in clock cycles must elapse before the bridges may run. The analog sensing sits outside the block, which sees every condition only as a synchronous digital flag.

Top module: `mdfs_supervisor`

## Requirements
- R1: In active mode, an overcurrent flag sampled high on OCP_CYC consecutive rising edges latches that bridge's overcurrent fault at the last of those edges. A low sample before then restarts the count from zero.
- R2: A latched overcurrent fault stays set through flag release, sleep and wake-up. Only the reset pin held low or the undervoltage flag at a clock edge clears it.
- R3: While ot_flag is high in waking or active mode, every bridge_off bit is 1 and fault_n is 0. Once ot_flag falls, both return to their values without overtemperature, and nothing is latched.
- R4: While uv_flag is high, it takes priority over all other inputs: every bridge_off bit is 1, supply_en is 0, inputs_ignored is 1 and ready is 0. Every latch and the wake timer clear at the next edge.
- R5: While rst_pin_n is low and uv_flag is low, every bridge_off bit is 1 and inputs_ignored is 1. supply_en stays 1 even if sleep_pin_n is also low, and the latches clear at the next edge.
- R6: While sleep_pin_n is low, with rst_pin_n high and uv_flag low, every bridge_off bit is 1, supply_en is 0 and inputs_ignored is 1. Overcurrent flags are not counted.
- R7: ready rises after WAKE_CYC consecutive rising edges with uv_flag low, rst_pin_n high and sleep_pin_n high. Until then every bridge_off bit is 1, and any blocking input restarts the interval.
- R8: fault_n is 0 exactly when some overcurrent latch is set, or ot_flag is high in waking or active mode. Otherwise fault_n is 1. An ot_flag during sleep or reset leaves fault_n at 1.
- R9: An overcurrent latch sets only its own bridge_off bit (bit i for bridge i). The other bridges keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset of all registers, active low |
| ocl_flag | input | NB | Per-bridge overcurrent-limit flag, bit i for bridge i |
| ot_flag | input | 1 | Overtemperature flag, high while hot |
| uv_flag | input | 1 | Supply undervoltage flag, high while low |
| rst_pin_n | input | 1 | Logic reset pin, active low |
| sleep_pin_n | input | 1 | Sleep request pin, active low |
| bridge_off | output | NB | Per-bridge disable, 1 turns all FETs of that bridge off |
| fault_n | output | 1 | Fault indication, active low |
| inputs_ignored | output | 1 | High whenever bridge control inputs must be disregarded |
| ready | output | 1 | High when bridges are allowed to run |
| supply_en | output | 1 | Enable for charge pump and regulator |

## Verification
The assertions assume that every flag and pin input is already synchronous to clk and changes only between edges. They also assume that por_n is asserted once at the start. The bench drives all inputs on the falling edge and releases por_n on a falling edge, so each flag is sampled cleanly at the following rising edge. Timing checks count rising edges from that falling-edge change. With short parameter overrides, both the persistence window and the wake interval are exercised exactly at their limits.

// File: rtl/mdfs_pkg.sv
package mdfs_pkg;
  typedef enum logic [2:0] {
    MD_UNDERV = 3'd0,
    MD_HELD   = 3'd1,
    MD_ASLEEP = 3'd2,
    MD_WAKING = 3'd3,
    MD_ACTIVE = 3'd4
  } mode_e;

  // true when one more qualifying sample completes the persistence window
  function automatic logic persist_hit(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

  // true when the wake interval has fully elapsed
  function automatic logic wake_elapsed(input int unsigned cnt, input int unsigned lim);
    return cnt >= lim;
  endfunction
endpackage

// File: rtl/mdfs_ocp_chan.sv
module mdfs_ocp_chan #(
  parameter int unsigned OCP_CYC = 8
) (
  input  logic clk,
  input  logic por_n,
  input  logic clr,
  input  logic cnt_en,
  input  logic flag,
  output logic lat
);
  import mdfs_pkg::*;
  localparam int unsigned CW = $clog2(OCP_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          lat_q;
  logic          qual;
  logic          hit;

  assign qual = cnt_en && flag;
  assign hit  = persist_hit(int'(cnt_q), OCP_CYC);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q <= '0;
      lat_q <= 1'b0;
    end else if (clr) begin
      cnt_q <= '0;
      lat_q <= 1'b0;
    end else if (qual) begin
      if (hit) lat_q <= 1'b1;
      else     cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  assign lat = lat_q;

  // R2: latch holds unless cleared
  p_latch_holds_r2: assert property (@(posedge clk) disable iff (!por_n)
    (lat_q && !clr) |=> lat_q);
  // R1: latch only rises after a qualifying flag sample
  p_latch_needs_flag_r1: assert property (@(posedge clk) disable iff (!por_n)
    $rose(lat_q) |-> ($past(flag) && $past(cnt_en)));
  // R1: counter never passes the window
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!por_n)
    int'(cnt_q) < OCP_CYC);
endmodule

// File: rtl/mdfs_wake_timer.sv
module mdfs_wake_timer #(
  parameter int unsigned WAKE_CYC = 250000
) (
  input  logic clk,
  input  logic por_n,
  input  logic blk,
  output logic done
);
  import mdfs_pkg::*;
  localparam int unsigned WW = $clog2(WAKE_CYC + 1);

  logic [WW-1:0] cnt_q;
  logic          done_w;

  assign done_w = wake_elapsed(int'(cnt_q), WAKE_CYC);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       cnt_q <= '0;
    else if (blk)     cnt_q <= '0;
    else if (!done_w) cnt_q <= cnt_q + 1'b1;
  end

  assign done = done_w;

  // R7: a blocking input always restarts the interval
  p_wake_blocked_r7: assert property (@(posedge clk) disable iff (!por_n)
    blk |=> !done);
  // R7: ready only appears after an unblocked edge
  p_wake_rise_r7: assert property (@(posedge clk) disable iff (!por_n)
    $rose(done) |-> !$past(blk));
endmodule

// File: rtl/mdfs_mode_sel.sv
module mdfs_mode_sel (
  input  logic             uv_flag,
  input  logic             rst_pin_n,
  input  logic             sleep_pin_n,
  input  logic             wake_done,
  output mdfs_pkg::mode_e  mode,
  output logic             blocked
);
  import mdfs_pkg::*;

  always_comb begin
    if (uv_flag)           mode = MD_UNDERV;
    else if (!rst_pin_n)   mode = MD_HELD;
    else if (!sleep_pin_n) mode = MD_ASLEEP;
    else if (!wake_done)   mode = MD_WAKING;
    else                   mode = MD_ACTIVE;
  end

  assign blocked = uv_flag || !rst_pin_n || !sleep_pin_n;

  // R4: undervoltage overrides every other mode
  always_comb begin
    if (uv_flag) p_uv_first_r4: assert (mode == MD_UNDERV);
  end
endmodule

// File: rtl/mdfs_supervisor.sv
module mdfs_supervisor #(
  parameter int unsigned NB       = 2,
  parameter int unsigned OCP_CYC  = 8,
  parameter int unsigned WAKE_CYC = 250000
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic [NB-1:0] ocl_flag,
  input  logic          ot_flag,
  input  logic          uv_flag,
  input  logic          rst_pin_n,
  input  logic          sleep_pin_n,
  output logic [NB-1:0] bridge_off,
  output logic          fault_n,
  output logic          inputs_ignored,
  output logic          ready,
  output logic          supply_en
);
  import mdfs_pkg::*;

  mode_e         mode;
  logic          blocked;
  logic          wake_done;
  logic          logic_clr;
  logic          run_now;
  logic          ot_live;
  logic [NB-1:0] ocp_lat;

  mdfs_mode_sel u_mode (
    .uv_flag     (uv_flag),
    .rst_pin_n   (rst_pin_n),
    .sleep_pin_n (sleep_pin_n),
    .wake_done   (wake_done),
    .mode        (mode),
    .blocked     (blocked)
  );

  mdfs_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk   (clk),
    .por_n (por_n),
    .blk   (blocked),
    .done  (wake_done)
  );

  assign logic_clr = (mode == MD_UNDERV) || (mode == MD_HELD);
  assign run_now   = (mode == MD_ACTIVE);

  for (genvar gi = 0; gi < NB; gi++) begin : g_chan
    mdfs_ocp_chan #(.OCP_CYC(OCP_CYC)) u_chan (
      .clk    (clk),
      .por_n  (por_n),
      .clr    (logic_clr),
      .cnt_en (run_now),
      .flag   (ocl_flag[gi]),
      .lat    (ocp_lat[gi])
    );
  end

  assign ot_live        = ot_flag && ((mode == MD_WAKING) || (mode == MD_ACTIVE));
  assign bridge_off     = {NB{!run_now || ot_live}} | ocp_lat;
  assign fault_n        = !((|ocp_lat) || ot_live);
  assign inputs_ignored = !run_now;
  assign ready          = run_now;
  assign supply_en      = !((mode == MD_UNDERV) || (mode == MD_ASLEEP));

  // R4: undervoltage wipes every latch by the next edge
  p_uv_wipes_r4: assert property (@(posedge clk) disable iff (!por_n)
    uv_flag |=> (ocp_lat == '0));
  // R5: reset pin clears latches too
  p_rst_wipes_r5: assert property (@(posedge clk) disable iff (!por_n)
    !rst_pin_n |=> (ocp_lat == '0));
  // R8: a reported fault in active mode always stops some bridge
  p_fault_stops_r8: assert property (@(posedge clk) disable iff (!por_n)
    (ready && !fault_n) |-> (bridge_off != '0));
  // R6: supply stays off while sleeping and not held in reset
  p_sleep_supply_r6: assert property (@(posedge clk) disable iff (!por_n)
    (!sleep_pin_n && rst_pin_n) |-> !supply_en);
endmodule

// File: tb/mdfs_supervisor_test.sv
module mdfs_supervisor_test;
  localparam int NB = 2;
  localparam int OCP = 8;
  localparam int WK = 20;

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic [NB-1:0] ocl_flag = '0;
  logic          ot_flag = 1'b0;
  logic          uv_flag = 1'b0;
  logic          rst_pin_n = 1'b1;
  logic          sleep_pin_n = 1'b1;
  logic [NB-1:0] bridge_off;
  logic          fault_n, inputs_ignored, ready, supply_en;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mdfs_supervisor #(.NB(NB), .OCP_CYC(OCP), .WAKE_CYC(WK)) uut (
    .clk(clk), .por_n(por_n), .ocl_flag(ocl_flag), .ot_flag(ot_flag),
    .uv_flag(uv_flag), .rst_pin_n(rst_pin_n), .sleep_pin_n(sleep_pin_n),
    .bridge_off(bridge_off), .fault_n(fault_n), .inputs_ignored(inputs_ignored),
    .ready(ready), .supply_en(supply_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle;
    #1;
  endtask

  task automatic t_reset_and_wake;
    settle();
    chk("R7 por ready", ready, 0);
    chk("R7 por bridges off", bridge_off, 3);
    chk("R8 por fault_n", fault_n, 1);
    @(negedge clk); por_n = 1'b1;
    tick(WK - 1);
    chk("R7 one edge early", ready, 0);
    chk("R7 off while waking", bridge_off, 3);
    tick(1);
    chk("R7 ready on time", ready, 1);
    chk("R7 bridges run", bridge_off, 0);
    chk("R7 inputs live", inputs_ignored, 0);
  endtask

  task automatic t_ocp_latch;
    ocl_flag = 2'b01; tick(OCP - 1);
    chk("R1 short pulse", fault_n, 1);
    ocl_flag = 2'b00; tick(1);
    ocl_flag = 2'b01; tick(OCP - 1);
    chk("R1 restart count", fault_n, 1);
    tick(1);
    chk("R1 latched", fault_n, 0);
    chk("R9 own bridge only", bridge_off, 1);
    ocl_flag = 2'b00; tick(3);
    chk("R2 held after release", fault_n, 0);
    sleep_pin_n = 1'b0; tick(2);
    chk("R6 sleep supply", supply_en, 0);
    chk("R6 sleep off", bridge_off, 3);
    chk("R2 held in sleep", fault_n, 0);
    sleep_pin_n = 1'b1; tick(WK);
    chk("R2 held after wake", fault_n, 0);
    chk("R2 bridge0 still off", bridge_off, 1);
    rst_pin_n = 1'b0; tick(1);
    chk("R5 reset clears", fault_n, 1);
    chk("R5 ignored", inputs_ignored, 1);
    rst_pin_n = 1'b1; tick(WK);
    chk("R5 back to run", bridge_off, 0);
  endtask

  task automatic t_sleep_ignore;
    sleep_pin_n = 1'b0; ocl_flag = 2'b11; tick(3 * OCP);
    chk("R6 ignored inputs", inputs_ignored, 1);
    chk("R6 no fault", fault_n, 1);
    sleep_pin_n = 1'b1; ocl_flag = 2'b00; tick(WK);
    chk("R6 no latch after", bridge_off, 0);
    rst_pin_n = 1'b0; sleep_pin_n = 1'b0; settle();
    chk("R5 supply over sleep", supply_en, 1);
    chk("R5 off", bridge_off, 3);
    @(negedge clk); rst_pin_n = 1'b1; sleep_pin_n = 1'b1;
    tick(WK / 2);
    sleep_pin_n = 1'b0; tick(1);
    sleep_pin_n = 1'b1; tick(WK - 1);
    chk("R7 restart interval", ready, 0);
    tick(1);
    chk("R7 ready after restart", ready, 1);
  endtask

  task automatic t_overtemp;
    ot_flag = 1'b1; settle();
    chk("R3 all off", bridge_off, 3);
    chk("R3 fault", fault_n, 0);
    @(negedge clk); ot_flag = 1'b0; settle();
    chk("R3 resume", bridge_off, 0);
    chk("R3 no latch", fault_n, 1);
    @(negedge clk); sleep_pin_n = 1'b0; ot_flag = 1'b1; settle();
    chk("R8 ot masked in sleep", fault_n, 1);
    @(negedge clk); ot_flag = 1'b0; sleep_pin_n = 1'b1; tick(WK);
  endtask

  task automatic t_undervolt;
    ocl_flag = 2'b10; tick(OCP);
    ocl_flag = 2'b00;
    chk("R9 bridge1 latched", bridge_off, 2);
    uv_flag = 1'b1; rst_pin_n = 1'b0; settle();
    chk("R4 supply off", supply_en, 0);
    chk("R4 all off", bridge_off, 3);
    chk("R4 ignored", inputs_ignored, 1);
    tick(1);
    chk("R4 latch wiped", fault_n, 1);
    uv_flag = 1'b0; rst_pin_n = 1'b1; tick(WK - 1);
    chk("R4 timer restarted", ready, 0);
    tick(1);
    chk("R4 ready again", ready, 1);
  endtask

  initial begin
    t_reset_and_wake();
    t_ocp_latch();
    t_sleep_ignore();
    t_overtemp();
    t_undervolt();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule